// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host bus and a battery-backed static memory and decides, cycle by cycle, whether the memory may be selected. It takes two digitised supply-status flags: one says the supply has dropped below the protection trip level, the other says it has dropped below the level where the backup cell must take over. It also takes the active-low bus strobes for chip enable, write enable and output enable. From these it produces a gated chip enable for the memory array, a hold-off that forces the data outputs to high impedance, a backup-cell select and a power-fail interrupt flag with its enable.

When the trip flag asserts while the bus is idle, the memory is locked at once. If an access is in flight, the lock waits for that access to end, but never longer than a fixed number of cycles. Once the supply comes back, the lock is kept for a recovery interval so that the host can settle before it touches the memory again. The backup-cell path stays open until the supply has been seen good once after reset. Both supply flags are first passed through a configurable synchroniser.

Top module: `pfw_sequencer`

## Requirements
- R1: During reset and on the first cycle after it, the memory is locked: `mem_ce_n`=1 and `oe_holdoff`=1. `bat_sel`, `pf_flag` and `pf_irq` are 0, and the interrupt enable is cleared.
- R2: While unlocked, `mem_ce_n` equals the `ce_n` sampled at the previous clock edge, and `oe_holdoff` is 0.
- R3: Each supply flag passes through SYNC_STAGES flip-flops. If the trip flag is seen with the bus idle, the lock (`mem_ce_n`=1, `oe_holdoff`=1) is visible after SYNC_STAGES+1 clock edges counted from the first edge that samples the raw flag.
- R4: An access is active when `ce_n`=0 and either `we_n`=0 or `oe_n`=0. If the trip flag is seen during an access, `mem_ce_n` keeps following `ce_n` and `oe_holdoff` stays 0. The lock is applied at the first edge that samples the bus idle.
- R5: If the access is still active TWPT edges after the edge that saw the trip flag, the lock is applied at that edge anyway.
- R6: While locked, `ce_n`, `we_n` and `oe_n` have no effect (`mem_ce_n` stays 1). A flag-read pulse (`flag_rd`) and an enable write (`ie_wr`) are also ignored.
- R7: After the synchronised trip flag clears, the lock is held. Normal access resumes TCER edges after the edge that saw the flag clear.
- R8: `bat_sel` follows the synchronised switchover flag. It stays 0 until that flag has been seen low at least once since reset.
- R9: `pf_flag` sets on the edge that sees the trip flag while unlocked. It clears on an unlocked `flag_rd`. If both happen on the same edge, setting wins.
- R10: `pf_irq` = `pf_flag` AND the interrupt enable. `ie_wr` loads the enable from `ie_din`. Reset clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| supply_low | input | 1 | Supply below protection trip level (asynchronous) |
| supply_dead | input | 1 | Supply below backup switchover level (asynchronous) |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| flag_rd | input | 1 | Pulse: software read of the flags location |
| ie_wr | input | 1 | Pulse: load the power-fail interrupt enable |
| ie_din | input | 1 | Value for the interrupt enable |
| mem_ce_n | output | 1 | Gated chip enable to the memory array, active low |
| oe_holdoff | output | 1 | 1 forces data outputs to high impedance |
| bat_sel | output | 1 | Selects the backup cell |
| pf_flag | output | 1 | Power-fail flag |
| pf_irq | output | 1 | Power-fail interrupt request |

## Verification
The bench aims at the exact edges where the lock engages and releases. If the lock came one cycle early, a drained read or write would be cut short. If it came one cycle late, after TWPT or TCER, the memory would be exposed while the supply sags or while the host is still settling. A held access tests the timeout: a design that only waits for the bus to go idle would never lock. Ignored strobes, flag reads and enable writes during the lock are each checked at the ports. So is the set-over-clear collision on the flag. The backup select is checked before its first arming, which catches a design that drains the cell before the first power-up.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_LOCK  = 2'd2,
    ST_HOLD  = 2'd3
  } pfw_state_t;

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= {STAGES{RST_VAL}};
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pfw_power.sv
module pfw_power #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic supply_dead,
  output logic trip_sync,
  output logic bat_sel
);

  logic dead_sync;
  logic armed_q;

  pfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_low (
    .clk(clk), .rst(rst), .d(supply_low), .q(trip_sync)
  );

  pfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dead (
    .clk(clk), .rst(rst), .d(supply_dead), .q(dead_sync)
  );

  // Backup path opens only once the supply has been seen good
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      bat_sel <= 1'b0;
    end else begin
      armed_q <= armed_q | ~dead_sync;
      bat_sel <= armed_q & dead_sync;
    end
  end

  AST_BAT_NEEDS_DEAD: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> $past(dead_sync)); // R8

  AST_BAT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_sel) |-> $past(armed_q)); // R8

endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
  import pfw_pkg::*;
#(
  parameter int TWPT  = 16,
  parameter int TCER  = 64,
  parameter int CNT_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic access,
  output logic prot_now,
  output logic prot_nxt,
  output logic trip_evt
);

  localparam logic [CNT_W-1:0] TWPT_C = CNT_W'(TWPT);
  localparam logic [CNT_W-1:0] TCER_C = CNT_W'(TCER);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  pfw_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    trip_evt = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (trip) begin
          trip_evt = 1'b1;
          if (access) begin
            state_d = ST_DRAIN;
            cnt_d   = ONE_C;
          end else begin
            state_d = ST_LOCK;
          end
        end
      end
      ST_DRAIN: begin
        if (!trip) begin
          state_d = ST_RUN;
        end else if (!access || cnt_q == TWPT_C) begin
          state_d = ST_LOCK;
        end else begin
          cnt_d = cnt_q + ONE_C;
        end
      end
      ST_LOCK: begin
        if (!trip) begin
          state_d = ST_HOLD;
          cnt_d   = ONE_C;
        end
      end
      ST_HOLD: begin
        if (trip) begin
          state_d = ST_LOCK;
        end else if (cnt_q == TCER_C) begin
          state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + ONE_C;
        end
      end
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOCK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign prot_now = (state_q == ST_LOCK) || (state_q == ST_HOLD);
  assign prot_nxt = (state_d == ST_LOCK) || (state_d == ST_HOLD);

  AST_DRAIN_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |-> $past(access)); // R4

  AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |-> (cnt_q <= TWPT_C)); // R5

  AST_HOLD_FROM_LOCK: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_HOLD) && !$past(state_q == ST_HOLD)) |-> $past(state_q == ST_LOCK)); // R7

  AST_RUN_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && $past(state_q == ST_HOLD)) |-> !$past(trip)); // R7

endmodule

// File: rtl/pfw_gate.sv
module pfw_gate (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic prot_nxt,
  output logic mem_ce_n,
  output logic oe_holdoff
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      oe_holdoff <= 1'b1;
    end else begin
      mem_ce_n   <= ce_n | prot_nxt;
      oe_holdoff <= prot_nxt;
    end
  end

  AST_CE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !oe_holdoff |-> (mem_ce_n == $past(ce_n))); // R2

endmodule

// File: rtl/pfw_irq.sv
module pfw_irq (
  input  logic clk,
  input  logic rst,
  input  logic trip_evt,
  input  logic prot_now,
  input  logic flag_rd,
  input  logic ie_wr,
  input  logic ie_din,
  output logic pf_flag,
  output logic pf_irq
);

  logic ie_q;
  logic flag_d, ie_d;

  always_comb begin
    ie_d   = (ie_wr && !prot_now) ? ie_din : ie_q;
    flag_d = trip_evt | (pf_flag & ~(flag_rd & ~prot_now));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= 1'b0;
      pf_flag <= 1'b0;
      pf_irq  <= 1'b0;
    end else begin
      ie_q    <= ie_d;
      pf_flag <= flag_d;
      pf_irq  <= flag_d & ie_d;
    end
  end

  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_flag) |-> $past(trip_evt)); // R9

  AST_FLAG_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(pf_flag) |-> ($past(flag_rd) && !$past(prot_now))); // R9

endmodule

// File: rtl/pfw_sequencer.sv
module pfw_sequencer
  import pfw_pkg::*;
#(
  parameter int TWPT        = 16,
  parameter int TCER        = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic supply_dead,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic flag_rd,
  input  logic ie_wr,
  input  logic ie_din,
  output logic mem_ce_n,
  output logic oe_holdoff,
  output logic bat_sel,
  output logic pf_flag,
  output logic pf_irq
);

  localparam int CNT_W = cnt_width(TWPT, TCER);

  logic trip_sync;
  logic access;
  logic prot_now, prot_nxt, trip_evt;

  assign access = ~ce_n & (~we_n | ~oe_n);

  pfw_power #(.SYNC_STAGES(SYNC_STAGES)) u_power (
    .clk(clk), .rst(rst),
    .supply_low(supply_low), .supply_dead(supply_dead),
    .trip_sync(trip_sync), .bat_sel(bat_sel)
  );

  pfw_seq #(.TWPT(TWPT), .TCER(TCER), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst),
    .trip(trip_sync), .access(access),
    .prot_now(prot_now), .prot_nxt(prot_nxt), .trip_evt(trip_evt)
  );

  pfw_gate u_gate (
    .clk(clk), .rst(rst),
    .ce_n(ce_n), .prot_nxt(prot_nxt),
    .mem_ce_n(mem_ce_n), .oe_holdoff(oe_holdoff)
  );

  pfw_irq u_irq (
    .clk(clk), .rst(rst),
    .trip_evt(trip_evt), .prot_now(prot_now),
    .flag_rd(flag_rd), .ie_wr(ie_wr), .ie_din(ie_din),
    .pf_flag(pf_flag), .pf_irq(pf_irq)
  );

  AST_LOCK_IGNORES_BUS: assert property (@(posedge clk) disable iff (rst)
    ($past(oe_holdoff) && oe_holdoff) |-> mem_ce_n); // R6

endmodule

// File: tb/pfw_sequencer_tb_top.sv
module pfw_sequencer_tb_top;

  localparam int TWPT = 8;
  localparam int TCER = 12;
  localparam int L    = 2;

  logic clk = 1'b0;
  logic rst;
  logic supply_low, supply_dead, ce_n, we_n, oe_n, flag_rd, ie_wr, ie_din;
  logic mem_ce_n, oe_holdoff, bat_sel, pf_flag, pf_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pfw_sequencer #(.TWPT(TWPT), .TCER(TCER), .SYNC_STAGES(L)) dut_i (
    .clk(clk), .rst(rst),
    .supply_low(supply_low), .supply_dead(supply_dead),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .flag_rd(flag_rd), .ie_wr(ie_wr), .ie_din(ie_din),
    .mem_ce_n(mem_ce_n), .oe_holdoff(oe_holdoff), .bat_sel(bat_sel),
    .pf_flag(pf_flag), .pf_irq(pf_irq)
  );

  // {ce_n, we_n, oe_n, expected mem_ce_n} in unlocked mode
  localparam logic [3:0] VEC [0:5] = '{
    4'b0010, 4'b0100, 4'b1111, 4'b0110, 4'b1001, 4'b0000
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic power_up();
    supply_dead = 1'b0; supply_low = 1'b0;
    cyc(L + TCER);
    chk("R7", "holdoff before recovery ends", oe_holdoff, 1'b1);
    cyc(1);
    chk("R7", "holdoff after recovery", oe_holdoff, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; supply_low = 1'b1; supply_dead = 1'b1;
    bus_idle(); flag_rd = 1'b0; ie_wr = 1'b0; ie_din = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1", "mem_ce_n", mem_ce_n, 1'b1);
    chk("R1", "oe_holdoff", oe_holdoff, 1'b1);
    chk("R1", "bat_sel", bat_sel, 1'b0);
    chk("R1", "pf_flag", pf_flag, 1'b0);
    chk("R1", "pf_irq", pf_irq, 1'b0);

    power_up();

    // R2: table walk in unlocked mode
    for (int i = 0; i < 6; i++) begin
      {ce_n, we_n, oe_n} = VEC[i][3:1];
      cyc(1);
      chk("R2", "mem_ce_n follows ce_n", mem_ce_n, VEC[i][0]);
      chk("R2", "oe_holdoff low", oe_holdoff, 1'b0);
    end

    // R3: trip with idle bus
    bus_idle();
    supply_low = 1'b1;
    cyc(L);
    chk("R3", "not yet locked", oe_holdoff, 1'b0);
    chk("R9", "flag not yet set", pf_flag, 1'b0);
    cyc(1);
    chk("R3", "locked", oe_holdoff, 1'b1);
    chk("R9", "flag set", pf_flag, 1'b1);
    // R6: bus, read and enable write ignored
    ce_n = 1'b0; we_n = 1'b0; flag_rd = 1'b1; ie_wr = 1'b1; ie_din = 1'b1;
    cyc(1);
    chk("R6", "ce ignored", mem_ce_n, 1'b1);
    flag_rd = 1'b0; ie_wr = 1'b0;
    cyc(1);
    chk("R6", "flag read ignored", pf_flag, 1'b1);
    // R8: backup select after arming
    supply_dead = 1'b1;
    cyc(L);
    chk("R8", "bat_sel before sync", bat_sel, 1'b0);
    cyc(1);
    chk("R8", "bat_sel asserted", bat_sel, 1'b1);
    supply_dead = 1'b0;
    cyc(L + 1);
    chk("R8", "bat_sel cleared", bat_sel, 1'b0);
    bus_idle();
    power_up();
    chk("R6", "flag survived locked read", pf_flag, 1'b1);
    chk("R10", "enable write ignored", pf_irq, 1'b0);
    flag_rd = 1'b1;
    cyc(1);
    flag_rd = 1'b0;
    chk("R9", "flag cleared by read", pf_flag, 1'b0);
    ie_wr = 1'b1; ie_din = 1'b1;
    cyc(1);
    ie_wr = 1'b0;
    chk("R10", "no irq without flag", pf_irq, 1'b0);

    // R4: trip during access, access ends early
    ce_n = 1'b0; oe_n = 1'b0;
    cyc(1);
    supply_low = 1'b1;
    cyc(L + 1);
    chk("R4", "drain: holdoff low", oe_holdoff, 1'b0);
    chk("R4", "drain: ce passes", mem_ce_n, 1'b0);
    chk("R10", "irq with flag and enable", pf_irq, 1'b1);
    cyc(2);
    chk("R4", "still draining", oe_holdoff, 1'b0);
    bus_idle();
    cyc(1);
    chk("R4", "locked when idle", oe_holdoff, 1'b1);
    chk("R4", "ce blocked", mem_ce_n, 1'b1);
    power_up();
    flag_rd = 1'b1;
    cyc(1);
    flag_rd = 1'b0;

    // R5: access held past the timeout
    ce_n = 1'b0; we_n = 1'b0;
    cyc(1);
    supply_low = 1'b1;
    cyc(L + TWPT);
    chk("R5", "open until timeout", oe_holdoff, 1'b0);
    chk("R5", "ce open until timeout", mem_ce_n, 1'b0);
    cyc(1);
    chk("R5", "forced lock", oe_holdoff, 1'b1);
    chk("R5", "ce forced high", mem_ce_n, 1'b1);
    bus_idle();
    power_up();

    // R1/R8/R10: second reset clears enable, backup stays isolated
    rst = 1'b1; supply_low = 1'b1; supply_dead = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk("R1", "flag after reset", pf_flag, 1'b0);
    chk("R1", "irq after reset", pf_irq, 1'b0);
    cyc(L + 2);
    chk("R8", "unarmed bat_sel", bat_sel, 1'b0);
    power_up();
    supply_low = 1'b1;
    cyc(L);
    flag_rd = 1'b1;
    cyc(1);
    flag_rd = 1'b0;
    chk("R9", "set wins over read", pf_flag, 1'b1);
    chk("R10", "enable cleared by reset", pf_irq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule